// File: doc/BRIEF.md
# Windowed Overcurrent Trip Combiner

This block is the digital protection path of a three-phase rectifier controller. Five sampled signed codes arrive together: three phase currents and two DC-bus voltages. Each code is checked against its own upper and lower limit, so a channel faults when the signal leaves its window in either direction. Each window result passes through an N-of-M sample filter. The filtered channel faults are then joined with active-high gate-driver fault pins into one source vector.

A routing mask chooses which sources may trip. Any enabled source that is active sets a latched trip. The trip drives every PWM output low at once, with no software step in the path. A sticky cause vector records every enabled source that was active while the trip was being set or held. Software writes the limits, the filter setting, the mask and a clear command through a simple write port. A clear is refused while any enabled source is still active.

Top module: `ocp_trip_combiner`

## Requirements
- R1: After reset, `trip` and `cause` are zero and `pwm_out` equals `pwm_in`. Every upper limit resets to the largest positive code and every lower limit to the most negative code, so no sample faults. The mask resets to all ones, and the filter resets to M=1, N=1.
- R2: Samples and limits are two's complement. A channel's window result is 1 when its sample is strictly greater than its upper limit or strictly less than its lower limit. A sample equal to a limit is not a fault.
- R3: A channel's filtered fault is 1 when at least N of the last M window results are 1. The history advances only on a cycle with `smp_vld` high. The filtered fault is visible on `src_live` one clock after the sample's edge.
- R4: Write addresses are: 2*i for the upper limit of channel i, 2*i+1 for its lower limit, 10 for the filter setting, 11 for the mask, and 12 for the clear command. The filter setting holds M-1 in bits [2:0] and N in bits [6:3]; an N of 0 behaves as 1. A clear happens only when data bit 0 is 1.
- R5: Source bits 0 to 4 are channels 0 to 4. Source bits 5 and 6 are `ext_flt[0]` and `ext_flt[1]`. The external pins are active high and unfiltered, and they appear on `src_live` in the same cycle.
- R6: A source whose mask bit is 0 never sets `trip` and never sets its bit in `cause`.
- R7: When an enabled source is active at a clock edge, `trip` is 1 after that edge. From then on, `pwm_out` is all zeros until a clear succeeds.
- R8: At every edge, `cause` gains each enabled source that is active. Its bits stay set until a clear succeeds.
- R9: A clear at an edge where no enabled source is active sets `trip` and `cause` to zero. A clear at an edge where an enabled source is active is ignored, so the fault wins and the trip stays set, even when the trip was not set before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample set is present on `smp` |
| smp | input | 60 | Five signed 12-bit codes, channel i in bits [12i+11:12i] |
| ext_flt | input | 2 | Active-high gate-driver fault pins |
| pwm_in | input | 6 | PWM commands from the modulator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| pwm_out | output | 6 | PWM commands after trip gating |
| trip | output | 1 | Latched trip |
| cause | output | 7 | Sticky record of the enabled sources that caused the trip |
| src_live | output | 7 | Live source vector: filtered channels, then external pins |

## Verification
The two functions that can fall in one cycle are a software clear and a newly active enabled fault. The bench provokes this by raising a gate-driver pin in the same cycle as the clear write, both on an untripped block and on a block that is already tripped. In both cases the result after that edge is judged at the ports: `trip` must be 1, `pwm_out` must be zero, and `cause` must hold the new source. A later clear, issued after the pin has dropped, must then release the outputs.

// File: rtl/ocp_trip_combiner.sv
module ocp_trip_combiner #(
  parameter int W    = 12,
  parameter int NCH  = 5,
  parameter int NEXT = 2,
  parameter int NPWM = 6,
  parameter int HMAX = 8,
  localparam int NSRC = NCH + NEXT,
  localparam int AW   = $clog2(2*NCH + 3),
  localparam int MB   = $clog2(HMAX),
  localparam int NB   = $clog2(HMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [NCH*W-1:0]  smp,
  input  logic [NEXT-1:0]   ext_flt,
  input  logic [NPWM-1:0]   pwm_in,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [NPWM-1:0]   pwm_out,
  output logic              trip,
  output logic [NSRC-1:0]   cause,
  output logic [NSRC-1:0]   src_live
);
  localparam logic [AW-1:0] A_FILT = AW'(2*NCH);
  localparam logic [AW-1:0] A_MASK = AW'(2*NCH + 1);
  localparam logic [AW-1:0] A_CLR  = AW'(2*NCH + 2);

  logic [MB-1:0]   mcfg;
  logic [NB-1:0]   ncfg;
  logic [NSRC-1:0] mask_q;
  logic [NCH-1:0]  flt;
  logic [HMAX-1:0] wmask;
  logic [NSRC-1:0] act;
  logic            trip_q;
  logic [NSRC-1:0] cause_q;
  logic            clr_req, clr_take, cfg_wr;

  assign wmask = {HMAX{1'b1}} >> (MB'(HMAX - 1) - mcfg);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic signed [W-1:0] hi, lo, s;
    logic [HMAX-1:0]     hist;
    logic [NB-1:0]       cnt;
    logic                win;

    assign s   = smp[i*W +: W];
    assign win = (s > hi) || (s < lo);
    assign cnt = NB'($countones(hist & wmask));
    assign flt[i] = (ncfg == '0) ? (cnt != '0) : (cnt >= ncfg);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi   <= {1'b0, {(W-1){1'b1}}};
        lo   <= {1'b1, {(W-1){1'b0}}};
        hist <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(2*i))     hi <= wr_data;
        if (wr_en && wr_addr == AW'(2*i + 1)) lo <= wr_data;
        if (smp_vld) hist <= {hist[HMAX-2:0], win};
      end
    end
  end

  assign src_live = {ext_flt, flt};
  assign act      = src_live & mask_q;
  assign cfg_wr   = wr_en && wr_addr == A_FILT;
  assign clr_req  = wr_en && wr_addr == A_CLR && wr_data[0];
  assign clr_take = clr_req && !(|act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcfg   <= '0;
      ncfg   <= NB'(1);
      mask_q <= '1;
    end else begin
      if (cfg_wr) begin
        mcfg <= wr_data[MB-1:0];
        ncfg <= wr_data[MB+NB-1:MB];
      end
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_q  <= 1'b0;
      cause_q <= '0;
    end else if (clr_take) begin
      trip_q  <= 1'b0;
      cause_q <= '0;
    end else begin
      if (|act) trip_q <= 1'b1;
      cause_q <= cause_q | act;
    end
  end

  assign trip    = trip_q;
  assign cause   = cause_q;
  assign pwm_out = trip_q ? '0 : pwm_in;

  assert_filter_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !cfg_wr) |=> $stable(flt));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|act) && !trip_q) |=> (!trip_q && cause_q == '0));

  assert_source_trips_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|act) |=> (trip_q && pwm_out == '0));

  assert_rise_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> $past(|act));

  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_take |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  assert_trip_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q == (cause_q != '0));

  assert_clear_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (|act)) |=> trip_q);
endmodule

// File: tb/tb_ocp_trip_combiner.sv
module tb_ocp_trip_combiner;
  localparam int W = 12, NCH = 5, NEXT = 2, NPWM = 6, NSRC = 7;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, wr_en = 1'b0;
  logic [NCH*W-1:0] smp = '0;
  logic [NEXT-1:0] ext_flt = '0;
  logic [NPWM-1:0] pwm_in = 6'b101101;
  logic [3:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [NPWM-1:0] pwm_out;
  logic trip;
  logic [NSRC-1:0] cause, src_live;
  int n_chk = 0, n_bad = 0;

  ocp_trip_combiner dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .ext_flt(ext_flt),
    .pwm_in(pwm_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .trip(trip), .cause(cause), .src_live(src_live));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic send(input int ch, input int v);
    smp = '0;
    smp[ch*W +: W] = W'(v);
    smp_vld = 1'b1;
    tick();
    smp_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 trip", 32'(trip), 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 pwm", 32'(pwm_out), 32'(pwm_in));
    smp = '0;
    smp[0 +: W] = 12'h7FF;
    smp[W +: W] = 12'h800;
    smp_vld = 1'b1; tick(); smp_vld = 1'b0;
    chk("R1 extremes no fault", 32'(src_live), 0);
    tick();
    chk("R1 no trip", 32'(trip), 0);
  endtask

  task automatic t_window;
    wr(2, 100); wr(3, -50);
    send(1, 100);  chk("R2 equal hi", 32'(src_live), 0);
    send(1, -50);  chk("R2 equal lo", 32'(src_live), 0);
    send(1, 101);  chk("R2 above hi", 32'(src_live), 32'h02);
    send(1, -51);  chk("R2 below lo", 32'(src_live), 32'h02);
    send(1, 0);    chk("R2 back inside", 32'(src_live), 0);
    chk("R7 trip latched", 32'(trip), 1);
    chk("R8 cause ch1", 32'(cause), 32'h02);
    wr(9, -10);
    send(4, -11);  chk("R4 ch4 lo addr", 32'(src_live), 32'h10);
    send(4, 0);
    chk("R8 cause ch1+ch4", 32'(cause), 32'h12);
    wr(12, 1);
    chk("R9 clear ok", 32'(trip), 0);
    chk("R9 cause cleared", 32'(cause), 0);
  endtask

  task automatic t_filter;
    wr(0, 10);
    wr(10, 3 | (3 << 3));
    send(0, 20); chk("R3 1 of 4", 32'(src_live[0]), 0);
    tick(3);     chk("R3 idle holds", 32'(src_live[0]), 0);
    send(0, 0);
    send(0, 20); chk("R3 2 of 4", 32'(src_live[0]), 0);
    send(0, 20); chk("R3 3 of 4", 32'(src_live[0]), 1);
    tick(2);     chk("R3 idle keeps fault", 32'(src_live[0]), 1);
    send(0, 0);  chk("R3 drops to 2", 32'(src_live[0]), 0);
    send(0, 20); chk("R3 back to 3", 32'(src_live[0]), 1);
    for (int k = 0; k < 4; k++) send(0, 0);
    chk("R3 flushed", 32'(src_live[0]), 0);
    wr(10, 1 << 3);
    wr(12, 1);
    chk("R9 clear after filter", 32'(trip), 0);
  endtask

  task automatic t_mask;
    wr(11, 7'b1011111);
    ext_flt = 2'b01; tick(2);
    chk("R5 ext live", 32'(src_live), 32'h20);
    chk("R6 masked no trip", 32'(trip), 0);
    chk("R6 masked pwm", 32'(pwm_out), 32'(pwm_in));
    ext_flt = 2'b10; tick();
    chk("R7 trip one edge", 32'(trip), 1);
    chk("R7 pwm low", 32'(pwm_out), 0);
    chk("R6 cause excludes masked", 32'(cause), 32'h40);
    ext_flt = 2'b00; tick();
    wr(11, 7'h7F); wr(12, 1);
    chk("R9 released", 32'(trip), 0);
  endtask

  task automatic t_sticky;
    pwm_in = 6'b010011; tick();
    chk("R7 pwm follows", 32'(pwm_out), 32'h13);
    ext_flt = 2'b01; tick();
    ext_flt = 2'b00; tick();
    ext_flt = 2'b10; tick();
    ext_flt = 2'b00; tick();
    chk("R8 both sticky", 32'(cause), 32'h60);
    chk("R7 still held", 32'(pwm_out), 0);
    wr(12, 0);
    chk("R4 clear bit0 zero ignored", 32'(trip), 1);
    wr(12, 1);
    chk("R8 cleared", 32'(cause), 0);
  endtask

  task automatic t_clear_block;
    ext_flt = 2'b01; tick();
    wr(12, 1);
    chk("R9 clear refused", 32'(trip), 1);
    chk("R9 cause kept", 32'(cause), 32'h20);
    ext_flt = 2'b00; tick();
    wr(12, 1);
    chk("R9 clear accepted", 32'(trip), 0);
    chk("R9 pwm restored", 32'(pwm_out), 32'(pwm_in));
  endtask

  task automatic t_same_cycle;
    ext_flt = 2'b10;
    wr(12, 1);
    chk("R9 same edge fault wins", 32'(trip), 1);
    chk("R9 same edge cause", 32'(cause), 32'h40);
    chk("R7 same edge pwm", 32'(pwm_out), 0);
    ext_flt = 2'b01;
    wr(12, 1);
    chk("R9 tripped fault wins", 32'(trip), 1);
    chk("R8 tripped cause grows", 32'(cause), 32'h60);
    ext_flt = 2'b00; tick();
    wr(12, 1);
    chk("R9 final clear", 32'(trip), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_window();
    t_filter();
    t_mask();
    t_sticky();
    t_clear_block();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule